// File: doc/BRIEF.md
# Dual-Clock Replay FIFO

A first-in first-out buffer whose write port and read port run on unrelated clocks. Words written on the write clock are stored in a small RAM. The read side delivers them in order in one of two read styles, picked by a mode input. In standard mode each word is popped by a read strobe. In fall-through mode the oldest word is already presented on the data output, and a read strobe moves on to the next word.

A rewind strobe on the read side moves the read pointer back to RAM location 0. Every word written since reset can then be read a second time, as long as no more words were written than the RAM holds. After a rewind the read side runs a short setup window before data flows again, and the form of that window depends on the read mode.

Four status flags describe the fill level, each in its own timing domain. A read-side flag shows whether data is available. An almost-empty flag is registered on the read clock. A half-full flag is decoded from read-side pointers. An almost-full flag is decoded from write-side pointers. Thresholds are parameters. All strobes are active low.

Top module: `rtx_async_fifo`

## Requirements
- R1: After both resets, `rd_status` is 0 in standard mode and 1 in fall-through mode, `wr_full`, `almost_full` and `half_full` are 0, `almost_empty` is 1 and `rd_data` is 0.
- R2: In standard mode (`fwft_sel`=0) a word is read only at a `rd_clk` rising edge with `rd_en_n`=0 and `rd_status`=1; `rd_data` takes the oldest word at that edge; words come out in write order and `rd_data` does not change without a read.
- R3: In fall-through mode (`fwft_sel`=1) `rd_status` goes to 0 with the oldest word on `rd_data` without any read strobe; a `rd_en_n`=0 edge while `rd_status`=0 consumes that word and the next one follows in write order.
- R4: `wr_full` is 1 when the RAM holds DEPTH words (DEPTH+1 words counting the output stage in fall-through mode); a write while `wr_full`=1 is ignored and no extra word is ever read out.
- R5: A read strobe while no word is available (`rd_status`=0 in standard mode, 1 in fall-through mode) changes neither `rd_data` nor the read position.
- R6: A `rewind_n`=0 sample at a `rd_clk` rising edge sets the read pointer to location 0; the words written since reset are then read again in write order, and the write pointer is unchanged, so reading stops after the last word written.
- R7: In standard mode, after a rewind taken at edge E0, `rd_status` is 0 after E0 and after E1, and becomes 1 after E2 when data is present; a read strobe is needed for every word, including the first.
- R8: In fall-through mode, after a rewind at E0, `rd_status` is 1 after E0, E1 and E2, and goes to 0 after E3 together with the word from location 0 on `rd_data`.
- R9: `almost_empty` is 1 when the read-side fill level is at most AE_LEVEL; it is registered twice on `rd_clk`, so after a rewind at E0 it changes after E2 and not before.
- R10: `half_full` is 1 when the read-side fill level exceeds DEPTH/2; after a rewind it reflects the new read pointer right after E0.
- R11: `almost_full` is 1 when the write-side fill level is at least DEPTH-AF_LEVEL; after a rewind at E0 it is unchanged after the first `wr_clk` rising edge following E0 and updated after the second.
- R12: A rewind is ignored when more than DEPTH words have been written since reset: `rd_status`, `rd_data` and the read order continue as if no rewind had been requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en_n | input | 1 | Active-low write strobe |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room for another word |
| almost_full | output | 1 | Write-side fill level at or above DEPTH-AF_LEVEL |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en_n | input | 1 | Active-low read strobe |
| rewind_n | input | 1 | Active-low rewind request, sampled on rd_clk |
| fwft_sel | input | 1 | Read style: 0 standard, 1 fall-through; changed only in reset |
| rd_data | output | DATA_W | Output word |
| rd_status | output | 1 | Standard: 1 when a word can be read; fall-through: 0 when rd_data holds a valid word |
| almost_empty | output | 1 | Read-side fill level at or below AE_LEVEL, two-stage registered |
| half_full | output | 1 | Read-side fill level above DEPTH/2 |

## Verification
On every cycle the assertions check that a rewind leaves the read pointer at zero, that the setup window holds the status flag at its "not available" value in each mode, that reads with no data and writes while full move no pointer, that the read-side fill level never exceeds the depth, and that full implies almost-full. Only the bench scenarios can show that replayed data matches the words written since reset, the edge-exact recovery of each flag after a rewind on its own clock, the extra word of capacity in fall-through mode, and that a rewind after the RAM has wrapped leaves the read order untouched.

// File: rtl/rtx_fifo_pkg.sv
// Shared types and constants for the dual-clock replay FIFO.
// Assumes: the read mode is held stable outside reset.
package rtx_fifo_pkg;

    // Read-side presentation style
    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_FALLTHRU = 1'b1
    } rd_mode_e;

    // Number of read edges the rewind setup window blocks data movement
    localparam int SETUP_EDGES = 2;

endpackage

// File: rtl/rtx_ptr_sync.sv
// Carries a Gray-coded pointer into another clock domain and converts it
// back to binary. Assumes the source pointer is registered and changes by
// one Gray step at a time during normal operation.
module rtx_ptr_sync #(
    parameter int PW     = 5,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_i,
    output logic [PW-1:0] bin_o
);

    logic [PW-1:0] pipe [STAGES];

    // First capture flop of the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= gray_i;
    end

    // Remaining flops of the chain, one per extra stage
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
        end
    end

    // Gray to binary: each bit is the parity of the bits at and above it
    always_comb begin
        for (int b = 0; b < PW; b++) begin
            bin_o[b] = ^(pipe[STAGES-1] >> b);
        end
    end

endmodule

// File: rtl/rtx_fifo_ram.sv
// Storage array: written on the write clock, read combinationally by the
// read side. Assumes the read side only addresses words whose write has
// already crossed the pointer synchronizer.
module rtx_fifo_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per accepted write
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rtx_fifo_wr_ctrl.sv
// Write-side control: owns the write pointer, decides acceptance, and
// derives full and almost-full from the synchronized read pointer.
// Assumes the read pointer input is already in this clock domain.
module rtx_fifo_wr_ctrl #(
    parameter int ADDR_W   = 4,
    parameter int AF_LEVEL = 3
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W:0]   rd_ptr_sync,
    output logic [ADDR_W:0]   wr_gray_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_we_o,
    output logic              wr_full_o,
    output logic              almost_full_o
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] wr_next;
    logic [PW-1:0] fill;

    assign fill          = wr_ptr - rd_ptr_sync;
    assign wr_full_o     = (fill == PW'(DEPTH));
    assign almost_full_o = (fill >= PW'(DEPTH - AF_LEVEL));
    assign wr_we_o       = !wr_en_n && !wr_full_o;
    assign wr_next       = wr_ptr + PW'(1);
    assign wr_addr_o     = wr_ptr[ADDR_W-1:0];

    // Advance binary and Gray write pointers on each accepted write
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wr_ptr    <= '0;
            wr_gray_o <= '0;
        end else if (wr_we_o) begin
            wr_ptr    <= wr_next;
            wr_gray_o <= wr_next ^ (wr_next >> 1);
        end
    end

    // R4: a write strobe while full must not move the pointer
    p_no_write_when_full_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_full_o && !wr_en_n) |=> (wr_ptr == $past(wr_ptr)));

    // R11: the almost-full threshold lies below the full level
    p_full_implies_af_r11: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_full_o |-> almost_full_o);

endmodule

// File: rtl/rtx_fifo_rd_ctrl.sv
// Read-side control: owns the read pointer, the output register, the
// rewind setup window and the read-domain flags. Assumes the write pointer
// input is already synchronized to rd_clk and mode only changes in reset.
module rtx_fifo_rd_ctrl
    import rtx_fifo_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int AE_LEVEL = 2
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en_n,
    input  logic              rewind_n,
    input  rd_mode_e          mode,
    input  logic [ADDR_W:0]   wr_ptr_sync,
    input  logic [DATA_W-1:0] ram_q,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [ADDR_W:0]   rd_gray_o,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_status,
    output logic              almost_empty,
    output logic              half_full
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] rd_next;
    logic [PW-1:0] fill;
    logic [1:0]    setup_cnt;
    logic          busy;
    logic          wrapped;
    logic          take_rewind;
    logic          has_data;
    logic          rd_ok;
    logic          out_valid;
    logic          std_pop;
    logic          fall_load;
    logic          advance;
    logic          ae_stage;

    assign fill        = wr_ptr_sync - rd_ptr;
    assign has_data    = (fill != '0);
    assign busy        = (setup_cnt != '0);
    assign take_rewind = !rewind_n && !wrapped;
    assign rd_ok       = !busy && !take_rewind && has_data;
    assign std_pop     = (mode == RD_STANDARD) && rd_ok && !rd_en_n;
    assign fall_load   = (mode == RD_FALLTHRU) && rd_ok && (!out_valid || !rd_en_n);
    assign advance     = std_pop || fall_load;
    assign rd_addr_o   = rd_ptr[ADDR_W-1:0];
    assign half_full   = (fill > PW'(DEPTH / 2));
    assign rd_status   = (mode == RD_STANDARD) ? (!busy && has_data) : !out_valid;

    // Next read position: rewind wins over a read at the same edge
    always_comb begin
        if (take_rewind)  rd_next = '0;
        else if (advance) rd_next = rd_ptr + PW'(1);
        else              rd_next = rd_ptr;
    end

    // Binary and Gray read pointers
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_ptr    <= '0;
            rd_gray_o <= '0;
        end else begin
            rd_ptr    <= rd_next;
            rd_gray_o <= rd_next ^ (rd_next >> 1);
        end
    end

    // Sticky marker: more words written than the RAM holds, rewind unsafe
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)                        wrapped <= 1'b0;
        else if (wr_ptr_sync > PW'(DEPTH))    wrapped <= 1'b1;
    end

    // Setup window length counter started by an accepted rewind
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)        setup_cnt <= '0;
        else if (take_rewind) setup_cnt <= 2'(SETUP_EDGES);
        else if (busy)        setup_cnt <= setup_cnt - 2'd1;
    end

    // Fall-through output stage occupancy
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)                                out_valid <= 1'b0;
        else if (take_rewind)                         out_valid <= 1'b0;
        else if (fall_load)                           out_valid <= 1'b1;
        else if (mode == RD_FALLTHRU && !rd_en_n)     out_valid <= 1'b0;
    end

    // Output data register, loaded whenever the pointer advances
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n)    rd_data <= '0;
        else if (advance) rd_data <= ram_q;
    end

    // Two-stage registered almost-empty flag
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            ae_stage     <= 1'b1;
            almost_empty <= 1'b1;
        end else begin
            ae_stage     <= (fill <= PW'(AE_LEVEL));
            almost_empty <= ae_stage;
        end
    end

    // R6: an accepted rewind leaves the pointer at location 0
    p_rewind_to_first_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        take_rewind |=> (rd_ptr == '0));

    // R5: with nothing stored, a read leaves pointer and data alone
    p_empty_read_ignored_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!has_data && rewind_n) |=> ((rd_ptr == $past(rd_ptr)) && $stable(rd_data)));

    // R4: read-side fill level never exceeds the RAM depth
    p_fill_bound_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        fill <= PW'(DEPTH));

    // R7: standard-mode setup keeps the status low for two edges
    p_std_setup_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (mode == RD_STANDARD && take_rewind) |=> !rd_status ##1 !rd_status);

    // R8: fall-through setup starts with output-ready deasserted
    p_fall_setup_r8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (mode == RD_FALLTHRU && take_rewind) |=> rd_status ##1 rd_status);

endmodule

// File: rtl/rtx_async_fifo.sv
// Dual-clock FIFO with rewind. Connects the storage array, both pointer
// controllers and the two Gray-pointer synchronizers.
// Assumes fwft_sel only changes while both resets are asserted.
module rtx_async_fifo
    import rtx_fifo_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int AE_LEVEL = 2,
    parameter int AF_LEVEL = 3
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              almost_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en_n,
    input  logic              rewind_n,
    input  logic              fwft_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_status,
    output logic              almost_empty,
    output logic              half_full
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_gray;
    logic [PW-1:0]     rd_gray;
    logic [PW-1:0]     wr_bin_at_rd;
    logic [PW-1:0]     rd_bin_at_wr;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] ram_q;
    logic              we;
    rd_mode_e          mode;

    assign mode = fwft_sel ? RD_FALLTHRU : RD_STANDARD;

    rtx_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (ram_q)
    );

    rtx_fifo_wr_ctrl #(.ADDR_W(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wr (
        .wr_clk        (wr_clk),
        .wr_rst_n      (wr_rst_n),
        .wr_en_n       (wr_en_n),
        .rd_ptr_sync   (rd_bin_at_wr),
        .wr_gray_o     (wr_gray),
        .wr_addr_o     (waddr),
        .wr_we_o       (we),
        .wr_full_o     (wr_full),
        .almost_full_o (almost_full)
    );

    rtx_fifo_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rd (
        .rd_clk       (rd_clk),
        .rd_rst_n     (rd_rst_n),
        .rd_en_n      (rd_en_n),
        .rewind_n     (rewind_n),
        .mode         (mode),
        .wr_ptr_sync  (wr_bin_at_rd),
        .ram_q        (ram_q),
        .rd_addr_o    (raddr),
        .rd_gray_o    (rd_gray),
        .rd_data      (rd_data),
        .rd_status    (rd_status),
        .almost_empty (almost_empty),
        .half_full    (half_full)
    );

    rtx_ptr_sync #(.PW(PW), .STAGES(2)) u_w2r (
        .clk    (rd_clk),
        .rst_n  (rd_rst_n),
        .gray_i (wr_gray),
        .bin_o  (wr_bin_at_rd)
    );

    rtx_ptr_sync #(.PW(PW), .STAGES(2)) u_r2w (
        .clk    (wr_clk),
        .rst_n  (wr_rst_n),
        .gray_i (rd_gray),
        .bin_o  (rd_bin_at_wr)
    );

endmodule

// File: tb/rtx_async_fifo_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: write tasks push expected words, the read-side
// monitor task pops and compares them as the design delivers them.
module rtx_async_fifo_tb_top;

    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 16;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          rewind_n = 1'b1;
    logic          fwft_sel = 1'b0;
    logic          wr_full, almost_full, rd_status, almost_empty, half_full;
    logic [DW-1:0] rd_data;

    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 0;
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] hist  [$];
    logic [DW-1:0] next_val;

    always #2 wr_clk = ~wr_clk;   // 250 MHz write clock
    always #3 rd_clk = ~rd_clk;   // slower, never-aligned read clock

    rtx_async_fifo #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(2), .AF_LEVEL(3)) dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .wr_full(wr_full), .almost_full(almost_full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en_n(rd_en_n), .rewind_n(rewind_n),
        .fwft_sel(fwft_sel), .rd_data(rd_data), .rd_status(rd_status),
        .almost_empty(almost_empty), .half_full(half_full)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset(input bit m);
        fwft_sel = m; wr_rst_n = 0; rd_rst_n = 0;
        wr_en_n = 1; rd_en_n = 1; rewind_n = 1;
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk) wr_rst_n = 1;
        @(negedge rd_clk) rd_rst_n = 1;
        exp_q.delete(); hist.delete();
        repeat (4) @(negedge rd_clk);
    endtask

    // Driver: one write, optionally recorded as expected
    task automatic put(input bit record);
        @(negedge wr_clk); wr_en_n = 0; wr_data = next_val;
        @(negedge wr_clk); wr_en_n = 1;
        if (record) begin
            hist.push_back(next_val); exp_q.push_back(next_val);
        end
        next_val = next_val + 1;
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    // Monitor: take one word from the design and compare with the queue
    task automatic take(input string tag);
        bit got = 0;
        for (int t = 0; t < 60 && !got; t++) begin
            @(negedge rd_clk);
            if (fwft_sel == 0 && rd_status == 1) got = 1;
            if (fwft_sel == 1 && rd_status == 0) got = 1;
        end
        if (!got || exp_q.size() == 0) begin
            chk({tag, " word available"}, 0, 1);
            return;
        end
        if (fwft_sel == 0) begin
            rd_en_n = 0; @(negedge rd_clk); rd_en_n = 1;
            chk({tag, " data"}, int'(rd_data), int'(exp_q.pop_front()));
        end else begin
            chk({tag, " data"}, int'(rd_data), int'(exp_q.pop_front()));
            rd_en_n = 0; @(negedge rd_clk); rd_en_n = 1;
        end
    endtask

    task automatic run_mode(input bit m);
        int empty_val;
        int nfill;
        logic [DW-1:0] held;
        empty_val = m ? 1 : 0;
        next_val  = m ? 8'h80 : 8'h10;
        do_reset(m);
        chk("R1 rd_status", int'(rd_status), empty_val);
        chk("R1 wr_full", int'(wr_full), 0);
        chk("R1 almost_full", int'(almost_full), 0);
        chk("R1 half_full", int'(half_full), 0);
        chk("R1 almost_empty", int'(almost_empty), 1);
        chk("R1 rd_data", int'(rd_data), 0);

        for (int i = 0; i < 14; i++) put(1);
        settle();
        chk("R10 half_full at 14", int'(half_full), 1);
        chk("R11 almost_full at 14", int'(almost_full), 1);
        chk("R9 almost_empty at 14", int'(almost_empty), 0);
        if (m) chk("R3 first word without read", int'(rd_data), int'(hist[0]));
        else   chk("R2 no change without read", int'(rd_data), 0);
        for (int i = 0; i < 12; i++) take(m ? "R3" : "R2");
        settle();
        chk("R9 almost_empty low fill", int'(almost_empty), 1);
        chk("R10 half_full low fill", int'(half_full), 0);
        chk("R11 almost_full low fill", int'(almost_full), 0);

        // Accepted rewind and per-flag recovery
        @(negedge rd_clk) rewind_n = 0;
        @(posedge rd_clk);
        fork
            begin
                @(posedge wr_clk); @(negedge wr_clk);
                chk("R11 almost_full after first wr edge", int'(almost_full), 0);
                @(posedge wr_clk); @(negedge wr_clk);
                chk("R11 almost_full after second wr edge", int'(almost_full), 1);
            end
            begin
                @(negedge rd_clk); rewind_n = 1;
                chk("R10 half_full right after rewind", int'(half_full), 1);
                chk(m ? "R8 status after E0" : "R7 status after E0", int'(rd_status), m ? 1 : 0);
                chk("R9 almost_empty after E0", int'(almost_empty), 1);
                @(negedge rd_clk);
                chk("R9 almost_empty after E1", int'(almost_empty), 1);
                chk(m ? "R8 status after E1" : "R7 status after E1", int'(rd_status), m ? 1 : 0);
                @(negedge rd_clk);
                chk("R9 almost_empty after E2", int'(almost_empty), 0);
                chk(m ? "R8 status after E2" : "R7 status after E2", int'(rd_status), 1);
                if (m) begin
                    @(negedge rd_clk);
                    chk("R8 status after E3", int'(rd_status), 0);
                    chk("R8 first word after E3", int'(rd_data), int'(hist[0]));
                end else begin
                    chk("R7 data held until strobe", int'(rd_data), int'(hist[11]));
                end
            end
        join
        exp_q = hist;
        for (int i = 0; i < 14; i++) take("R6 replay");
        settle();
        chk("R6 stops at write pointer", int'(rd_status), empty_val);

        // Rewind after the RAM wrapped is ignored
        for (int i = 0; i < 10; i++) put(1);
        settle();
        @(negedge rd_clk) rewind_n = 0;
        @(negedge rd_clk) rewind_n = 1;
        chk("R12 status unchanged", int'(rd_status), m ? 0 : 1);
        if (m) chk("R12 output word kept", int'(rd_data), int'(hist[14]));
        for (int i = 0; i < 10; i++) take("R12 order kept");
        settle();

        // Fill to full, one write refused
        nfill = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge wr_clk);
            if (!wr_full) begin put(1); nfill++; end
        end
        chk("R4 words accepted until full", nfill, m ? DEPTH + 1 : DEPTH);
        chk("R4 wr_full", int'(wr_full), 1);
        put(0);
        chk("R4 still full after refused write", int'(wr_full), 1);
        for (int i = 0; i < nfill; i++) take("R4 drain");
        settle();
        chk("R4 no extra word", int'(rd_status), empty_val);

        // Read strobe while empty
        held = rd_data;
        @(negedge rd_clk) rd_en_n = 0;
        @(negedge rd_clk) rd_en_n = 1;
        chk("R5 data unchanged on empty read", int'(rd_data), int'(held));
        chk("R5 still empty", int'(rd_status), empty_val);
        put(1);
        take("R5 next word after empty read");
        settle();
        chk("R5 empty again", int'(rd_status), empty_val);
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule